// File: doc/BRIEF.md
# Configuration Register Write-Protection Guard

This block guards a small configuration register bank that a serial peripheral reads its settings from. A control register carries an enable bit. While that bit is set, software writes to the two protected registers are refused: the peripheral mode register and the chip-select configuration register. A refused write does not change the register. It sets a sticky violation flag in a status register and stores the offset of the register the write was aimed at. Software reads the status register to learn what was refused, and that read clears the flag.

The bus is a simple memory-mapped port. It has a write side (enable, word address, data) and a read side (enable, word address, data). Each side has its own address, so a refused write and a status read can happen in the same cycle. Word offsets are fixed: 0 is the mode register, 1 is the chip-select register, 2 is the guard control register and 3 is the status register. The parameter `RD_REG` selects the read path. At 0 (the default) read data is combinational. At 1 read data is registered and appears one cycle later. In both cases the status flag clears at the clock edge that ends the read cycle.

Top module: `cfg_write_guard`

## Requirements
- R1: After reset, the mode register, the chip-select register, the control register and the status register all read as zero.
- R2: While the enable bit (control offset 2, bit 0) is clear, a write to offset 0 or offset 1 stores the full data word. The stored word reads back from the next cycle on.
- R3: While the enable bit is set, a write to offset 0 or offset 1 leaves that register's contents unchanged.
- R4: A refused write sets the violation flag, which is bit 0 of the status register at offset 3.
- R5: Status bits [8 +: ADDR_W] hold the offset targeted by the most recent refused write. Each later refused write overwrites that offset.
- R6: A status read returns the flag as it was before the read and clears it at the end of that cycle. The source field is kept. No other access clears the flag.
- R7: If a refused write and a status read fall in the same cycle, the read returns the old status. After that cycle the flag is set and the source holds the new offset.
- R8: The status register is read-only. A write to offset 3 changes neither the flag nor the source, and it is never counted as a violation.
- R9: The control register is writable whether or not protection is on. Only bit 0 is stored, and all its other bits read as zero.
- R10: A write to an unmapped offset (4 and above) changes no register and sets no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | ADDR_W | Word offset of the write |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe for one cycle; a status read also clears the flag |
| rd_addr | input | ADDR_W | Word offset of the read |
| rd_data | output | DATA_W | Read data, either combinational or one cycle late depending on `RD_REG` |

## Verification
Two events can meet in one cycle: a refused write that sets the flag and a status read that clears it. The bench provokes this by asserting the write side (aimed at the chip-select register with protection on) and a status read in the same cycle, starting from a cleared flag. The read must return the old, clear status. The next status read must show the flag set with the chip-select offset as its source, which shows that the set takes priority over the clear.

// File: rtl/cfgguard_pkg.sv
package cfgguard_pkg;

   // Word offsets of the guarded bank; the bench and software rely on them.
   localparam int unsigned OFS_MODE     = 0;
   localparam int unsigned OFS_SEL      = 1;
   localparam int unsigned OFS_CTRL     = 2;
   localparam int unsigned OFS_STAT     = 3;
   localparam int unsigned N_PROT       = 2;
   // Bit position of the source field in the status word.
   localparam int unsigned STAT_SRC_LSB = 8;

   typedef struct packed {
      logic mode;
      logic sel;
      logic ctrl;
      logic stat;
   } regsel_t;

endpackage

// File: rtl/guard_addr_decode.sv
module guard_addr_decode
   import cfgguard_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output regsel_t           hit
);

   always_comb begin
      hit      = '0;
      hit.mode = (addr == ADDR_W'(OFS_MODE));
      hit.sel  = (addr == ADDR_W'(OFS_SEL));
      hit.ctrl = (addr == ADDR_W'(OFS_CTRL));
      hit.stat = (addr == ADDR_W'(OFS_STAT));
   end

endmodule

// File: rtl/guard_cfg_reg.sv
module guard_cfg_reg #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic              lock,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_req && !lock) begin
         q <= wdata;
      end
   end

   // R3
   blocked_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && lock) |=> (q == $past(q)));

   // R2
   open_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !lock) |=> (q == $past(wdata)));

endmodule

// File: rtl/guard_status.sv
module guard_status #(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              viol,
   input  logic [ADDR_W-1:0] viol_src,
   input  logic              rd_clr,
   output logic              flag,
   output logic [ADDR_W-1:0] src
);

   // A new violation wins over a clearing read in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         src  <= '0;
      end else begin
         if (viol) begin
            flag <= 1'b1;
            src  <= viol_src;
         end else if (rd_clr) begin
            flag <= 1'b0;
         end
      end
   end

   // R4
   viol_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol |=> flag);

   // R5
   src_tracks_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol |=> (src == $past(viol_src)));

   // R6
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !viol) |=> !flag);

   // R6
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_clr && !viol) |=> ($stable(flag) && $stable(src)));

endmodule

// File: rtl/cfg_write_guard.sv
module cfg_write_guard
   import cfgguard_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned RD_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned STAT_TOP = STAT_SRC_LSB + ADDR_W;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("cfg_write_guard: ADDR_W must cover offsets 0..3");
      end
      if (DATA_W < STAT_TOP) begin : g_bad_data
         $error("cfg_write_guard: DATA_W too narrow for the status source field");
      end
      if (RD_REG > 1) begin : g_bad_rd
         $error("cfg_write_guard: RD_REG must be 0 or 1");
      end
   endgenerate

   regsel_t wsel, rsel;
   logic    prot_on;
   logic    stat_flag;
   logic    viol;
   logic    stat_rd;
   logic [ADDR_W-1:0] stat_src;
   logic [N_PROT-1:0] prot_wr;
   logic [DATA_W-1:0] prot_q [N_PROT];
   logic [DATA_W-1:0] rd_word;

   guard_addr_decode #(.ADDR_W(ADDR_W)) i_wdec (.addr(wr_addr), .hit(wsel));
   guard_addr_decode #(.ADDR_W(ADDR_W)) i_rdec (.addr(rd_addr), .hit(rsel));

   assign prot_wr[OFS_MODE] = wr_en && wsel.mode;
   assign prot_wr[OFS_SEL]  = wr_en && wsel.sel;

   generate
      for (genvar g = 0; g < N_PROT; g++) begin : g_prot
         guard_cfg_reg #(.DATA_W(DATA_W)) i_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_req(prot_wr[g]),
            .lock  (prot_on),
            .wdata (wr_data),
            .q     (prot_q[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_on <= 1'b0;
      end else if (wr_en && wsel.ctrl) begin
         prot_on <= wr_data[0];
      end
   end

   assign viol    = prot_on && (|prot_wr);
   assign stat_rd = rd_en && rsel.stat;

   guard_status #(.ADDR_W(ADDR_W)) i_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .viol    (viol),
      .viol_src(wr_addr),
      .rd_clr  (stat_rd),
      .flag    (stat_flag),
      .src     (stat_src)
   );

   always_comb begin
      rd_word = '0;
      if (rsel.mode) begin
         rd_word = prot_q[OFS_MODE];
      end else if (rsel.sel) begin
         rd_word = prot_q[OFS_SEL];
      end else if (rsel.ctrl) begin
         rd_word[0] = prot_on;
      end else if (rsel.stat) begin
         rd_word[0] = stat_flag;
         rd_word[STAT_SRC_LSB +: ADDR_W] = stat_src;
      end
   end

   generate
      if (RD_REG == 0) begin : g_rd_comb
         assign rd_data = rd_en ? rd_word : '0;
      end else begin : g_rd_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_data <= '0;
            end else begin
               rd_data <= rd_en ? rd_word : '0;
            end
         end
      end
   endgenerate

   // R9
   ctrl_always_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wsel.ctrl) |=> (prot_on == $past(wr_data[0])));

   // R8
   stat_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wsel.stat && !stat_rd) |=> ($stable(stat_flag) && $stable(stat_src)));

   // R10
   unmapped_no_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr > ADDR_W'(OFS_STAT))) |-> !viol);

endmodule

// File: tb/test_cfg_write_guard.sv
module test_cfg_write_guard;

   localparam int unsigned AW = 4;
   localparam int unsigned DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [DW-1:0] exp_mode = '0;
   logic [DW-1:0] exp_sel  = '0;

   always #5 clk = ~clk;

   cfg_write_guard #(.ADDR_W(AW), .DATA_W(DW), .RD_REG(0)) i_cfg_write_guard (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   function automatic logic [DW-1:0] stat_word(input logic f, input logic [AW-1:0] s);
      logic [DW-1:0] w;
      w = '0;
      w[0] = f;
      w[8 +: AW] = s;
      return w;
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      logic [DW-1:0] v;
      bus_rd(a, v);
      check(req, v, exp);
   endtask

   task automatic t_reset();
      rd_chk("R1 mode", 4'd0, '0);
      rd_chk("R1 sel",  4'd1, '0);
      rd_chk("R1 ctrl", 4'd2, '0);
      rd_chk("R1 stat", 4'd3, '0);
   endtask

   task automatic t_open();
      exp_mode = 32'hA5A5_0001; exp_sel = 32'h0000_1234;
      bus_wr(4'd0, exp_mode);
      bus_wr(4'd1, exp_sel);
      rd_chk("R2 mode write", 4'd0, exp_mode);
      rd_chk("R2 sel write",  4'd1, exp_sel);
      rd_chk("R2 no flag when open", 4'd3, '0);
   endtask

   task automatic t_ctrl();
      bus_wr(4'd2, 32'hFFFF_FFFF);
      rd_chk("R9 ctrl only bit0", 4'd2, 32'h1);
   endtask

   task automatic t_blocked();
      bus_wr(4'd0, 32'hDEAD_BEEF);
      rd_chk("R3 mode unchanged", 4'd0, exp_mode);
      rd_chk("R6 other read keeps flag", 4'd1, exp_sel);
      rd_chk("R4 flag set src mode", 4'd3, stat_word(1'b1, 4'd0));
      rd_chk("R6 flag cleared", 4'd3, stat_word(1'b0, 4'd0));
      bus_wr(4'd1, 32'h0BAD_0BAD);
      rd_chk("R3 sel unchanged", 4'd1, exp_sel);
      bus_wr(4'd0, 32'h1111_2222);
      bus_wr(4'd1, 32'h3333_4444);
      rd_chk("R5 src overwritten to sel", 4'd3, stat_word(1'b1, 4'd1));
      bus_wr(4'd0, 32'h5555_6666);
      rd_chk("R5 src overwritten to mode", 4'd3, stat_word(1'b1, 4'd0));
   endtask

   task automatic t_collide();
      logic [DW-1:0] v;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd1; wr_data = 32'h7777_7777;
      rd_en = 1'b1; rd_addr = 4'd3;
      #1 v = rd_data;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check("R7 same-cycle read old", v, stat_word(1'b0, 4'd0));
      rd_chk("R7 flag survives read", 4'd3, stat_word(1'b1, 4'd1));
      rd_chk("R7 sel unchanged", 4'd1, exp_sel);
   endtask

   task automatic t_stat_ro();
      bus_wr(4'd3, 32'hFFFF_FFFF);
      rd_chk("R8 stat write ignored", 4'd3, stat_word(1'b0, 4'd1));
   endtask

   task automatic t_unmapped();
      bus_wr(4'd7, 32'hCAFE_F00D);
      bus_wr(4'd15, 32'h0000_0001);
      rd_chk("R10 no flag", 4'd3, stat_word(1'b0, 4'd1));
      rd_chk("R10 mode kept", 4'd0, exp_mode);
      rd_chk("R10 ctrl kept", 4'd2, 32'h1);
   endtask

   task automatic t_disable();
      bus_wr(4'd2, 32'h0000_0000);
      rd_chk("R9 ctrl writable while on", 4'd2, 32'h0);
      exp_mode = 32'h0F0F_F0F0;
      bus_wr(4'd0, exp_mode);
      rd_chk("R2 write after disable", 4'd0, exp_mode);
      rd_chk("R2 no flag after disable", 4'd3, stat_word(1'b0, 4'd1));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_open();
      t_ctrl();
      t_blocked();
      t_collide();
      t_stat_ro();
      t_unmapped();
      t_disable();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule